// File: doc/BRIEF.md
# Top-of-Book Feature Extraction Pipeline

This block turns a stream of top-of-book snapshots into two fixed-point trading features. Each inbound beat carries the best bid price, the best ask price and the resting quantity on each side. For every beat the block produces a size-weighted micro-price and a signed volume imbalance, both in Q16.16. Both results are packed into one outbound beat.

Both features come from a quotient over the total displayed quantity. The quotients are formed by pipelined restoring division that resolves one quotient bit per stage, so no divide operator is needed. The two datapaths run in lockstep with the same fixed latency. The block accepts one beat per cycle. A valid flag and the frame-end marker travel with the data through every stage.

Flow control is a single global enable. When the downstream sink stops accepting, every stage freezes and the block stops accepting input. No beat can be lost or repeated.

Top module: `feat_extract`

## Requirements
- R1: The inbound 128-bit beat holds the bid price in [127:96], the ask price in [95:64], the bid quantity in [63:32] and the ask quantity in [31:0]. Prices are unsigned Q16.16 and quantities are unsigned integers.
- R2: The micro-price in m_tdata[63:32] equals bid + floor((ask − bid) × w / 65536), truncated to 32 bits.
  - w = floor(bid_qty × 65536 / (bid_qty + ask_qty)) and may reach 65536 (1.0).
  - ask − bid is signed, so a crossed book is allowed.
- R3: The imbalance in m_tdata[31:0] is two's complement. Its magnitude is floor(|bid_qty − ask_qty| × 65536 / (bid_qty + ask_qty)). It is negative when ask_qty > bid_qty, so it lies in [−65536, 65536].
- R4: When bid_qty + ask_qty is zero, the micro-price is floor((bid + ask) / 2) and the imbalance is zero.
- R5: With m_tready held high, a beat accepted on one clock edge appears on the outbound port 19 cycles later (FRAC + 3). Back-to-back beats come out on consecutive cycles.
- R6: s_tready follows m_tready. While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold their values.
- R7: m_tlast of each outbound beat equals s_tlast of the inbound beat it was computed from.
- R8: While rst_n is low, and on the first cycle after it, m_tvalid is low.
- R9: Outbound beats leave in the order the inbound beats were accepted. Each accepted beat yields exactly one outbound beat, and no outbound beat appears without an accepted beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | 128 | Inbound book snapshot (layout in R1) |
| s_tvalid | input | 1 | Inbound beat valid |
| s_tready | output | 1 | Block can accept an inbound beat |
| s_tlast | input | 1 | Inbound frame-end marker |
| m_tdata | output | 64 | Micro-price [63:32], imbalance [31:0] |
| m_tvalid | output | 1 | Outbound beat valid |
| m_tready | input | 1 | Sink can accept an outbound beat |
| m_tlast | output | 1 | Outbound frame-end marker |

## Verification
The bench builds the block with the default FRAC of 16 and 32-bit price and quantity fields, which gives a pipeline depth of 19 stages. With full-range quantities the total quantity carries into a 33rd bit, so the divider's widest remainder is exercised. Quantities drawn from the smallest range reach the exact 1.0 weight and the ±1.0 imbalance end points. Crossed books exercise the sign-extended spread product. A random sink that stalls about a third of the time exercises the hold and ordering rules while all 19 stages are full.

// File: rtl/feat_pkg.sv
package feat_pkg;
    localparam int PX_W  = 32;
    localparam int SZ_W  = 32;
    localparam int SUM_W = SZ_W + 1;
    localparam int SPR_W = PX_W + 1;
    localparam int IN_W  = 2 * PX_W + 2 * SZ_W;
    localparam int OUT_W = 2 * PX_W;

    // R1: inbound field order, most significant first
    typedef struct packed {
        logic [PX_W-1:0] bid_px;
        logic [PX_W-1:0] ask_px;
        logic [SZ_W-1:0] bid_sz;
        logic [SZ_W-1:0] ask_sz;
    } book_beat_t;

    // values that ride alongside the two dividers
    typedef struct packed {
        logic             vld;
        logic             last;
        logic             empty;
        logic             neg;
        logic [PX_W-1:0]  bid;
        logic [SPR_W-1:0] spread;
        logic [PX_W-1:0]  mid;
    } side_t;
endpackage

// File: rtl/feat_delay.sv
module feat_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) pipe[k] <= '0;
        end else if (en) begin
            pipe[0] <= din;
            for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign dout = pipe[DEPTH-1];
endmodule

// File: rtl/feat_frac_div.sv
// Restoring fractional divider for num <= den.
// Stage 0 resolves the integer bit; stages 1..FRAC each resolve one fraction bit.
module feat_frac_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 33,
    parameter int FRAC  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [FRAC:0]    quo
);
    localparam int QW = FRAC + 1;

    logic [DEN_W-1:0] rem_q  [FRAC];
    logic [DEN_W-1:0] den_q  [FRAC];
    logic [QW-1:0]    quo_q  [FRAC+1];
    logic             ge_w   [FRAC+1];
    logic [DEN_W-1:0] nrem_w [FRAC];
    logic [DEN_W-1:0] num_x;

    assign num_x     = {{(DEN_W-NUM_W){1'b0}}, num};
    assign ge_w[0]   = num_x >= den;
    assign nrem_w[0] = ge_w[0] ? num_x - den : num_x;

    for (genvar k = 1; k <= FRAC; k++) begin : g_stage
        assign ge_w[k] = {rem_q[k-1], 1'b0} >= {1'b0, den_q[k-1]};
        if (k < FRAC) begin : g_rem
            assign nrem_w[k] = DEN_W'(ge_w[k] ? {rem_q[k-1], 1'b0} - {1'b0, den_q[k-1]}
                                              : {rem_q[k-1], 1'b0});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < FRAC; k++) begin
                rem_q[k] <= '0;
                den_q[k] <= '0;
            end
            for (int k = 0; k <= FRAC; k++) quo_q[k] <= '0;
        end else if (en) begin
            rem_q[0] <= nrem_w[0];
            den_q[0] <= den;
            quo_q[0] <= QW'(ge_w[0]);
            for (int k = 1; k < FRAC; k++) begin
                rem_q[k] <= nrem_w[k];
                den_q[k] <= den_q[k-1];
            end
            for (int k = 1; k <= FRAC; k++) quo_q[k] <= (quo_q[k-1] << 1) | QW'(ge_w[k]);
        end
    end

    assign quo = quo_q[FRAC];
endmodule

// File: rtl/feat_extract.sv
module feat_extract
    import feat_pkg::*;
#(
    parameter int FRAC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  s_tdata,
    input  logic             s_tvalid,
    output logic             s_tready,
    input  logic             s_tlast,
    output logic [OUT_W-1:0] m_tdata,
    output logic             m_tvalid,
    input  logic             m_tready,
    output logic             m_tlast
);
    localparam int QW     = FRAC + 1;
    localparam int DIV_D  = FRAC + 1;
    localparam int PROD_W = SPR_W + QW + 1;

    logic adv;
    assign adv      = m_tready;
    assign s_tready = m_tready;

    book_beat_t beat;
    assign beat = s_tdata;

    // stage 1: operand preparation
    logic [SUM_W-1:0] sum_c;
    logic [SZ_W-1:0]  absd_c;
    side_t            side_c;

    always_comb begin
        sum_c         = {1'b0, beat.bid_sz} + {1'b0, beat.ask_sz};
        side_c.vld    = s_tvalid;
        side_c.last   = s_tlast;
        side_c.empty  = (sum_c == '0);
        side_c.neg    = beat.ask_sz > beat.bid_sz;
        absd_c        = side_c.neg ? beat.ask_sz - beat.bid_sz : beat.bid_sz - beat.ask_sz;
        side_c.bid    = beat.bid_px;
        side_c.spread = {1'b0, beat.ask_px} - {1'b0, beat.bid_px};
        side_c.mid    = PX_W'(({1'b0, beat.bid_px} + {1'b0, beat.ask_px}) >> 1);
    end

    side_t            p_side;
    logic [SUM_W-1:0] p_sum;
    logic [SZ_W-1:0]  p_bq;
    logic [SZ_W-1:0]  p_absd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_side <= '0;
            p_sum  <= '0;
            p_bq   <= '0;
            p_absd <= '0;
        end else if (adv) begin
            p_side <= side_c;
            p_sum  <= sum_c;
            p_bq   <= beat.bid_sz;
            p_absd <= absd_c;
        end
    end

    // stages 2..FRAC+2: the two dividers and the matching sideband delay
    logic [QW-1:0] w_q;
    logic [QW-1:0] i_q;
    side_t         d_side;

    feat_frac_div #(.NUM_W(SZ_W), .DEN_W(SUM_W), .FRAC(FRAC)) u_div_wt (
        .clk(clk), .rst_n(rst_n), .en(adv), .num(p_bq), .den(p_sum), .quo(w_q)
    );

    feat_frac_div #(.NUM_W(SZ_W), .DEN_W(SUM_W), .FRAC(FRAC)) u_div_imb (
        .clk(clk), .rst_n(rst_n), .en(adv), .num(p_absd), .den(p_sum), .quo(i_q)
    );

    feat_delay #(.W($bits(side_t)), .DEPTH(DIV_D)) u_side (
        .clk(clk), .rst_n(rst_n), .en(adv), .din(p_side), .dout(d_side)
    );

    // stage FRAC+3: weighting, sign and output register
    logic signed [PROD_W-1:0] spr_x;
    logic signed [PROD_W-1:0] w_x;
    logic [PX_W-1:0]          adj_c;
    logic [PX_W-1:0]          mp_c;
    logic [PX_W-1:0]          q_ext;
    logic [PX_W-1:0]          imb_c;

    always_comb begin
        spr_x = {{(PROD_W-SPR_W){d_side.spread[SPR_W-1]}}, d_side.spread};
        w_x   = {{(PROD_W-QW){1'b0}}, w_q};
        adj_c = PX_W'((spr_x * w_x) >>> FRAC);
        mp_c  = d_side.bid + adj_c;
        q_ext = {{(PX_W-QW){1'b0}}, i_q};
        imb_c = d_side.neg ? (~q_ext + 1'b1) : q_ext;
    end

    logic            o_vld;
    logic            o_last;
    logic [PX_W-1:0] o_mp;
    logic [PX_W-1:0] o_imb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld  <= 1'b0;
            o_last <= 1'b0;
            o_mp   <= '0;
            o_imb  <= '0;
        end else if (adv) begin
            o_vld  <= d_side.vld;
            o_last <= d_side.last;
            o_mp   <= d_side.empty ? d_side.mid : mp_c;
            o_imb  <= d_side.empty ? '0 : imb_c;
        end
    end

    assign m_tdata  = {o_mp, o_imb};
    assign m_tvalid = o_vld;
    assign m_tlast  = o_last;
endmodule

// File: rtl/feat_extract_chk.sv
module feat_extract_chk
    import feat_pkg::*;
#(
    parameter int FRAC = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_tvalid,
    input logic             s_tready,
    input logic [OUT_W-1:0] m_tdata,
    input logic             m_tvalid,
    input logic             m_tready,
    input logic             m_tlast
);
    localparam int LAT     = FRAC + 3;
    localparam int OCC_W   = $clog2(LAT + 2) + 1;
    localparam int IMB_MAX = 1 << FRAC;

    logic [OCC_W-1:0] occ;
    logic             acc;
    logic             emit;
    logic signed [PX_W-1:0] imb_s;

    assign acc   = s_tvalid && s_tready;
    assign emit  = m_tvalid && m_tready;
    assign imb_s = m_tdata[PX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= occ + OCC_W'(acc) - OCC_W'(emit);
    end

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

    // R3
    imb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (imb_s <= IMB_MAX) && (imb_s >= -IMB_MAX));

    // R9
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(LAT));

    // R9
    no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> occ != '0);

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !m_tvalid);
endmodule

bind feat_extract feat_extract_chk #(.FRAC(FRAC)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
);

// File: tb/feat_extract_bench.sv
`timescale 1ns/1ps
module feat_extract_bench;
    localparam int FRAC = 16;
    localparam int LAT  = FRAC + 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] s_tdata = '0;
    logic         s_tvalid = 1'b0;
    logic         s_tready;
    logic         s_tlast = 1'b0;
    logic [63:0]  m_tdata;
    logic         m_tvalid;
    logic         m_tready = 1'b0;
    logic         m_tlast;

    always #2 clk = ~clk;

    feat_extract #(.FRAC(FRAC)) u_feat_extract (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .s_tlast(s_tlast), .m_tdata(m_tdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int n_in   = 0;
    int n_out  = 0;
    bit mon_on = 0;
    bit nostall = 0;
    bit rand_on = 0;
    bit hold_pend = 0;
    logic [63:0] hold_data;
    logic        hold_last;

    logic [31:0] q_mp[$];
    logic [31:0] q_imb[$];
    bit          q_last[$];
    bit          q_zero[$];
    int          q_cyc[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] bid, input logic [31:0] ask,
                                  input logic [31:0] bq, input logic [31:0] aq,
                                  output logic [31:0] mp, output logic [31:0] imb);
        longint s, w, spr, adj, d, ad, q;
        s = longint'(bq) + longint'(aq);
        if (s == 0) begin
            mp  = 32'((longint'(bid) + longint'(ask)) >>> 1);
            imb = '0;
        end else begin
            w   = (longint'(bq) <<< FRAC) / s;
            spr = longint'(ask) - longint'(bid);
            adj = (spr * w) >>> FRAC;
            mp  = 32'(longint'(bid) + adj);
            d   = longint'(bq) - longint'(aq);
            ad  = (d < 0) ? -d : d;
            q   = (ad <<< FRAC) / s;
            imb = 32'((d < 0) ? -q : q);
        end
    endfunction

    // monitor: sampled on the falling edge, handshakes complete on the next rising edge
    always @(negedge clk) begin
        if (mon_on) begin
            logic [31:0] emp, eimb;
            bit el, ez;
            int ec;
            if (hold_pend)
                chk(m_tvalid && m_tdata == hold_data && m_tlast == hold_last,
                    "R6", "stalled output changed", longint'(m_tdata), longint'(hold_data));
            hold_pend = m_tvalid && !m_tready;
            hold_data = m_tdata;
            hold_last = m_tlast;
            if (m_tvalid && m_tready) begin
                if (q_mp.size() == 0) begin
                    chk(0, "R9", "output beat without input", n_out + 1, n_in);
                end else begin
                    emp = q_mp.pop_front(); eimb = q_imb.pop_front();
                    el = q_last.pop_front(); ez = q_zero.pop_front();
                    ec = q_cyc.pop_front();
                    n_out++;
                    chk(m_tdata[63:32] == emp, ez ? "R4" : "R2", "micro-price",
                        longint'(m_tdata[63:32]), longint'(emp));
                    chk(m_tdata[31:0] == eimb, ez ? "R4" : "R3", "imbalance",
                        longint'($signed(m_tdata[31:0])), longint'($signed(eimb)));
                    chk(m_tlast == el, "R7", "tlast", longint'(m_tlast), longint'(el));
                    if (nostall)
                        chk(cyc - ec == LAT, "R5", "latency", cyc - ec, LAT);
                end
            end
            if (s_tvalid && s_tready) begin
                // R1: field order of the inbound beat
                model(s_tdata[127:96], s_tdata[95:64], s_tdata[63:32], s_tdata[31:0], emp, eimb);
                q_mp.push_back(emp);
                q_imb.push_back(eimb);
                q_last.push_back(s_tlast);
                q_zero.push_back((s_tdata[63:32] == 0) && (s_tdata[31:0] == 0));
                q_cyc.push_back(cyc);
                n_in++;
            end
        end
    end

    task automatic put(input logic [31:0] bid, input logic [31:0] ask,
                       input logic [31:0] bq, input logic [31:0] aq, input bit last);
        s_tdata  = {bid, ask, bq, aq};
        s_tlast  = last;
        s_tvalid = 1'b1;
        @(negedge clk);
        while (!s_tready) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] rnd_qty();
        case ($urandom % 5)
            0: return 32'($urandom % 16);
            1: return 32'($urandom % 65536);
            2: return $urandom;
            3: return 32'hFFFF_FFFF - 32'($urandom % 4);
            default: return 32'($urandom % 3);
        endcase
    endfunction

    task automatic put_rand();
        logic [31:0] bid, ask;
        bid = $urandom;
        if ($urandom % 3 == 0) ask = $urandom;
        else ask = bid + 32'($urandom % 32'h0010_0000);
        put(bid, ask, rnd_qty(), rnd_qty(), ($urandom % 4) == 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        #1;
        chk(m_tvalid == 1'b0, "R8", "m_tvalid during reset", longint'(m_tvalid), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(m_tvalid == 1'b0, "R8", "m_tvalid after reset", longint'(m_tvalid), 0);
        m_tready = 1'b0;
        #1 chk(s_tready == 1'b0, "R6", "s_tready follows low m_tready", longint'(s_tready), 0);
        m_tready = 1'b1;
        #1 chk(s_tready == 1'b1, "R6", "s_tready follows high m_tready", longint'(s_tready), 1);
        @(posedge clk);
        #1;
        mon_on  = 1;
        nostall = 1;

        // directed corners, back to back
        put(32'h0064_0000, 32'h0065_0000, 32'd100, 32'd300, 1'b0);
        put(32'h0064_0000, 32'h0065_0000, 32'd0, 32'd0, 1'b1);        // R4 zero total
        put(32'h0000_0001, 32'h0000_0004, 32'd0, 32'd0, 1'b0);        // R4 odd price sum
        put(32'h0064_0000, 32'h0065_0000, 32'd500, 32'd0, 1'b1);      // R2 weight of 1.0
        put(32'h0064_0000, 32'h0065_0000, 32'd0, 32'd7, 1'b0);        // R3 imbalance of -1.0
        put(32'h0064_0000, 32'h0065_0000, 32'd42, 32'd42, 1'b0);      // R3 balanced
        put(32'h0065_0000, 32'h0064_0000, 32'd1, 32'd3, 1'b1);        // R2 crossed book
        put(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        put(32'h0000_0000, 32'hFFFF_FFFF, 32'd3, 32'd1, 1'b1);
        put(32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0);
        for (int i = 0; i < 60; i++) put_rand();
        s_tvalid = 1'b0;
        repeat (LAT + 4) @(posedge clk);
        #1;
        nostall = 0;

        // random sink stalls and random source gaps
        rand_on = 1;
        fork
            begin
                while (rand_on) begin
                    @(posedge clk);
                    #1;
                    m_tready = ($urandom % 10) < 7;
                end
            end
        join_none
        for (int i = 0; i < 800; i++) begin
            put_rand();
            if ($urandom % 4 == 0) begin
                s_tvalid = 1'b0;
                repeat (1 + $urandom % 3) @(posedge clk);
                #1;
            end
        end
        s_tvalid = 1'b0;
        rand_on  = 0;
        repeat (2) @(posedge clk);
        #1;
        m_tready = 1'b1;
        repeat (LAT + 6) @(posedge clk);
        #1;

        chk(q_mp.size() == 0, "R9", "beats still pending", q_mp.size(), 0);
        chk(n_out == n_in, "R9", "output count", n_out, n_in);
        mon_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        chk(0, "R9", "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule